// File: doc/BRIEF.md
# Synthesizer Reference Divider and Phase Comparator

This block is the digital comparison stage of a frequency-synthesis loop. It runs on a crystal clock and divides that clock to produce a comparison square wave. A second, faster square wave is divided from the same clock as an auxiliary clock output. The divided oscillator signal comes in on `div_in`, sampled on the crystal clock. It is compared with the reference square wave on falling edges.

When the divided signal falls first, the pump-down request is held high until the reference falls. When the reference falls first, the pump-up request is held high until the divided signal falls. Each request is therefore as wide as the edge separation, counted in clocks. When both edges land on the same clock, neither request rises. The charge-pump drive enable is active only while one of the requests is active, so the pump is high-impedance otherwise.

A lock monitor counts comparison cycles, ending each cycle at a reference falling edge. Lock is declared after a set number of consecutive clean cycles. A cycle is clean when no request lasts longer than a programmable threshold. Lock is lost as soon as a request outlasts the threshold. Lock drives an active-low indicator and a current-range select, which picks the reduced pump current while locked. There is no data stream here, so every pin is a plain level.

Top module: `synth_phase_compare`

## Requirements
- R1: After reset, `ref_out` is high for the first REF_DIV/2 clocks and then low for the remaining REF_DIV/2 clocks. It repeats with a period of REF_DIV clocks (default 1536).
- R2: `tap_out` is high for TAP_DIV/2 clocks and then low for TAP_DIV/2 clocks. It repeats with a period of TAP_DIV clocks (default 48) and starts high after reset.
- R3: When `div_in` falls k clocks before `ref_out` falls, `dn` is high for exactly k consecutive clocks. `up` stays low during this.
- R4: When `ref_out` falls k clocks before `div_in` falls, `up` is high for exactly k consecutive clocks. `dn` stays low during this.
- R5: Falls of both signals on the same clock raise neither output. `up` and `dn` are never high together. When a second edge arrives while the opposite request is pending, that request is cleared on the same clock.
- R6: `pump_en` is 1 exactly while `up` or `dn` is 1. A value of 0 selects the high-impedance pump.
- R7: `lock_n` goes to 0 on the reference falling edge that completes LOCK_CYCLES consecutive comparison cycles (default 4). In each of those cycles, no request may be active for more than `thresh` clocks.
- R8: A request active for `thresh`+1 clocks sets `lock_n` to 1 on the clock that ends that high cycle. That comparison cycle then does not count as clean. A request exactly `thresh` clocks wide keeps lock.
- R9: `cur_low` is the inverse of `lock_n`. A value of 1 selects the low pump range (100 units) and 0 the high range (300 units).
- R10: During reset the outputs take fixed values: `up`=0, `dn`=0, `pump_en`=0, `lock_n`=1, `cur_low`=0, `ref_out`=1 and `tap_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_in | input | 1 | Divided oscillator signal, synchronous to clk |
| thresh | input | THR_W | Longest request width, in clocks, still counted as clean |
| ref_out | output | 1 | Comparison reference square wave |
| tap_out | output | 1 | Auxiliary divided clock |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| pump_en | output | 1 | Pump drive enable (0 = high impedance) |
| lock_n | output | 1 | Lock indicator, 0 when locked |
| cur_low | output | 1 | Pump current range, 1 = low |

## Verification
The assertions take for granted that `div_in` and `thresh` are synchronous to `clk` and settle well before each rising edge. They also assume that reset lasts at least one clock. The bench drives every input on the falling clock edge to meet this.

A phase offset may only change at a point where the old and new divided waveforms have the same level. The bench changes the offset only when the reference counter is a quarter of the way into its period, where every offset used gives a high level. As a result, no extra edge is injected that could pair with the wrong reference edge.

// File: rtl/synth_cmp_pkg.sv
package synth_cmp_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;
endpackage

// File: rtl/clk_divider.sv
module clk_divider #(
  parameter int unsigned DIV = 1536
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  localparam int unsigned CW   = (DIV < 2) ? 1 : $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign wave = (cnt < CW'(HALF));
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import synth_cmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_lvl,
  input  logic      div_lvl,
  output pump_req_t req,
  output logic      ref_fall
);
  logic      ref_d, div_d, div_fall;
  pump_req_t nxt;

  always_comb begin
    ref_fall = ref_d & ~ref_lvl;
    div_fall = div_d & ~div_lvl;
    nxt.up   = req.up | ref_fall;
    nxt.dn   = req.dn | div_fall;
    // second edge of a pair cancels both requests on the same clock
    if (nxt.up && nxt.dn) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      div_d <= 1'b0;
      req   <= '0;
    end else begin
      ref_d <= ref_lvl;
      div_d <= div_lvl;
      req   <= nxt;
    end
  end
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int unsigned THR_W       = 12,
  parameter int unsigned LOCK_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             cycle_end,
  input  logic [THR_W-1:0] thresh,
  output logic             locked
);
  localparam int unsigned GW = $clog2(LOCK_CYCLES + 1);
  localparam logic [THR_W-1:0] LMAX = '1;

  logic [THR_W-1:0] len;
  logic [GW-1:0]    good, good_nx;
  logic             bad, wide;

  assign wide    = active && (len >= thresh);
  assign good_nx = (good == GW'(LOCK_CYCLES)) ? good : good + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len    <= '0;
      good   <= '0;
      bad    <= 1'b0;
      locked <= 1'b0;
    end else begin
      if (!active) len <= '0;
      else if (len != LMAX) len <= len + 1'b1;

      if (wide) begin
        good   <= '0;
        bad    <= 1'b1;
        locked <= 1'b0;
      end else if (cycle_end) begin
        if (bad) begin
          good <= '0;
          bad  <= 1'b0;
        end else begin
          good   <= good_nx;
          locked <= (good_nx == GW'(LOCK_CYCLES));
        end
      end
    end
  end
endmodule

// File: rtl/synth_phase_compare.sv
module synth_phase_compare
  import synth_cmp_pkg::*;
#(
  parameter int unsigned REF_DIV     = 1536,
  parameter int unsigned TAP_DIV     = 48,
  parameter int unsigned LOCK_CYCLES = 4,
  parameter int unsigned THR_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_in,
  input  logic [THR_W-1:0] thresh,
  output logic             ref_out,
  output logic             tap_out,
  output logic             up,
  output logic             dn,
  output logic             pump_en,
  output logic             lock_n,
  output logic             cur_low
);
  localparam int unsigned NDIV = 2;
  localparam int unsigned DIVS [NDIV] = '{REF_DIV, TAP_DIV};

  logic [NDIV-1:0] waves;
  pump_req_t       req;
  logic            ref_fall, locked;

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    clk_divider #(.DIV(DIVS[i])) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .wave (waves[i])
    );
  end

  assign ref_out = waves[0];
  assign tap_out = waves[1];

  pfd_core u_pfd (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_lvl (ref_out),
    .div_lvl (div_in),
    .req     (req),
    .ref_fall(ref_fall)
  );

  lock_monitor #(.THR_W(THR_W), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (req.up | req.dn),
    .cycle_end(ref_fall),
    .thresh   (thresh),
    .locked   (locked)
  );

  assign up      = req.up;
  assign dn      = req.dn;
  assign pump_en = req.up | req.dn;
  assign lock_n  = ~locked;
  assign cur_low = locked;
endmodule

// File: rtl/synth_phase_compare_chk.sv
module synth_phase_compare_chk (
  input logic clk,
  input logic rst_n,
  input logic div_in,
  input logic ref_out,
  input logic up,
  input logic dn,
  input logic lock_n
);
  // R5: the two requests are mutually exclusive
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  // R3: a down request only starts after a falling edge of the divided input
  assert_dn_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> ($past(div_in, 2) && !$past(div_in, 1)));

  // R4: an up request only starts after a falling edge of the reference
  assert_up_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> ($past(ref_out, 2) && !$past(ref_out, 1)));

  // R7: lock is only declared at the end of a comparison cycle
  assert_lock_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> ($past(ref_out, 2) && !$past(ref_out, 1)));

  // R8: lock is only lost while a request is active
  assert_drop_on_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n) |-> $past(up || dn));
endmodule

bind synth_phase_compare synth_phase_compare_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .div_in (div_in),
  .ref_out(ref_out),
  .up     (up),
  .dn     (dn),
  .lock_n (lock_n)
);

// File: tb/synth_phase_compare_test.sv
`timescale 1ns/1ps
module synth_phase_compare_test;
  localparam int N    = 1536;
  localparam int HALF = N / 2;
  localparam int TAPN = 48;
  localparam int LOCKN = 4;
  localparam int LMAX = 4095;
  localparam int MARK = 384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_in = 1'b1;
  logic [11:0] thresh = 12'd20;
  logic ref_out, tap_out, up, dn, pump_en, lock_n, cur_low;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_phase_compare uut (
    .clk(clk), .rst_n(rst_n), .div_in(div_in), .thresh(thresh),
    .ref_out(ref_out), .tap_out(tap_out), .up(up), .dn(dn),
    .pump_en(pump_en), .lock_n(lock_n), .cur_low(cur_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int k = 0;
  int off = 0;
  bit m_up, m_dn, m_lock, m_bad, pref, pdiv;
  int len, good;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k = 0; m_up = 0; m_dn = 0; m_lock = 0; m_bad = 0;
      pref = 0; pdiv = 0; len = 0; good = 0;
    end else begin
      bit rl, fr, fd, act, wide, nu, nd;
      rl   = (k % N) < HALF;
      fr   = pref && !rl;
      fd   = pdiv && !div_in;
      act  = m_up || m_dn;
      wide = act && (len >= int'(thresh));
      nu   = m_up || fr;
      nd   = m_dn || fd;
      if (nu && nd) begin nu = 0; nd = 0; end
      if (act) len = (len < LMAX) ? len + 1 : len; else len = 0;
      if (wide) begin
        good = 0; m_lock = 0; m_bad = 1;
      end else if (fr) begin
        if (m_bad) begin good = 0; m_bad = 0; end
        else begin
          if (good < LOCKN) good++;
          m_lock = (good == LOCKN);
        end
      end
      m_up = nu; m_dn = nd; pref = rl; pdiv = div_in;
      k++;
    end
  end

  // divided-signal stimulus with a programmable phase offset
  always @(negedge clk) div_in <= (((k + off) % N) < HALF);

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 ref_out", ref_out, int'((k % N) < HALF));
      chk("R2 tap_out", tap_out, int'((k % TAPN) < TAPN / 2));
      chk("R3 dn", dn, m_dn);
      chk("R4 up", up, m_up);
      chk("R6 pump_en", pump_en, int'(m_up || m_dn));
      chk("R7 lock_n", lock_n, int'(!m_lock));
      chk("R9 cur_low", cur_low, m_lock);
    end
  end

  // pulse-width measurement windows
  bit meas_on = 0;
  int urun, drun, umax, dmax, both;
  always @(negedge clk) begin
    if (!meas_on) begin
      urun = 0; drun = 0; umax = 0; dmax = 0; both = 0;
    end else begin
      urun = up ? urun + 1 : 0;
      drun = dn ? drun + 1 : 0;
      if (urun > umax) umax = urun;
      if (drun > dmax) dmax = drun;
      if (up && dn) both++;
    end
  end

  task automatic to_mark();
    do @(negedge clk); while ((k % N) != MARK);
  endtask

  task automatic run(input int periods);
    repeat (periods * N) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: values held during reset
    chk("R10 up", up, 0);
    chk("R10 dn", dn, 0);
    chk("R10 pump_en", pump_en, 0);
    chk("R10 lock_n", lock_n, 1);
    chk("R10 cur_low", cur_low, 0);
    chk("R10 ref_out", ref_out, 1);
    chk("R10 tap_out", tap_out, 1);
    rst_n = 1'b1;

    // in phase: no requests, lock after four clean cycles (R5, R7)
    to_mark();
    meas_on = 1;
    run(6);
    chk("R5 in-phase up width", umax, 0);
    chk("R5 in-phase dn width", dmax, 0);
    chk("R7 locked in phase", lock_n, 0);
    meas_on = 0;

    // divided input leads by 10 clocks (R3), lock held
    off = 10;
    run(1);
    meas_on = 1;
    run(3);
    chk("R3 dn width lead 10", dmax, 10);
    chk("R3 no up on lead", umax, 0);
    chk("R8 lock held below threshold", lock_n, 0);
    meas_on = 0;

    // lead by 50 exceeds threshold 20: lock lost (R8, R9)
    off = 50;
    run(1);
    meas_on = 1;
    run(3);
    chk("R3 dn width lead 50", dmax, 50);
    chk("R8 lock lost on wide pulse", lock_n, 1);
    chk("R9 high current when unlocked", cur_low, 0);
    meas_on = 0;

    // divided input lags by 30 clocks (R4), threshold 40 relocks
    thresh = 12'd40;
    off = N - 30;
    run(1);
    meas_on = 1;
    run(5);
    chk("R4 up width lag 30", umax, 30);
    chk("R4 no dn on lag", dmax, 0);
    chk("R5 never both high", both, 0);
    chk("R7 relocked on lag", lock_n, 0);
    chk("R9 low current when locked", cur_low, 1);
    meas_on = 0;

    // boundary: width equal to threshold keeps lock, one more drops it (R8)
    thresh = 12'd30;
    run(2);
    chk("R8 width equal to threshold keeps lock", lock_n, 0);
    thresh = 12'd29;
    run(2);
    chk("R8 width one over threshold drops lock", lock_n, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule